// File: doc/BRIEF.md
# 64b/66b Self-Synchronizing Payload Scrambler

This block whitens the 64-bit payload of each 66-bit line block. It runs the payload through a multiplicative LFSR built on the polynomial x^58 + x^39 + 1. The two sync-header bits are not touched and leave in the same block as their payload. One instance handles a full block per clock and registers the result, so the output appears one cycle after the input.

The 58-bit state keeps running from block to block. It advances only on cycles that carry a valid block. While reset is asserted, the state loads either all ones or a seed taken from a port.

A mode input turns the same datapath into the matching descrambler. In that mode, the received bit is fed back into the state in place of the output bit. Because of this, a descrambler recovers the payload once it has seen 58 scrambled bits, whatever seed it started from. A transmit instance and a receive instance can therefore be chained back to back without agreeing on a seed.

Top module: `pcs_scrambler66`

## Requirements
- R1: Block layout: `in_block[1:0]` and `out_block[1:0]` hold the sync header. Bits `[65:2]` hold the payload, and payload bit 0 (`in_block[2]`) is processed first.
- R2: On every valid block, the header leaves on `out_block[1:0]` unchanged, one clock after it entered.
- R3: For each payload bit d, in order, the output bit is d XOR s[38] XOR s[57]. The state then shifts up one place (s[57] is dropped) and the feedback bit enters at s[0].
- R4: The state carries over from one valid block to the next, with no restart between blocks.
- R5: While `rst_n` is low and `seed_override` is 0, the state loads all ones.
- R6: While `rst_n` is low and `seed_override` is 1, the state loads `seed_i`.
- R7: With `descramble`=1, the feedback bit is the input bit. With `descramble`=0, it is the output bit.
- R8: A descrambler fed by a scrambler's output reproduces every payload from the second block onward, even when the two were reset with different seeds.
- R9: On a cycle with `in_valid` low, neither the state nor `out_block` changes.
- R10: `out_valid` is `in_valid` delayed by one clock. During reset, `out_valid` and `out_block` clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the seed |
| descramble | input | 1 | 0 = scramble, 1 = descramble; hold static outside reset |
| seed_override | input | 1 | 1 = reset loads `seed_i`, 0 = reset loads all ones |
| seed_i | input | 58 | Reset seed used when `seed_override` is 1 |
| in_valid | input | 1 | Input block strobe |
| in_block | input | 66 | Input block: header in [1:0], payload in [65:2] |
| out_valid | output | 1 | Output block strobe |
| out_block | output | 66 | Output block, same layout as the input |

## Verification
On every cycle, the assertions check the following: the seed loaded at reset release, that the state and the output word freeze on idle cycles, the one-cycle delay of the strobe, and that the header passes through intact. Only the bench scenarios can show that the payload bits follow the tap and feedback rule and that the state carries across blocks. The same holds for self-synchronization: the bench compares against an independent bit-serial model and chains a scrambler into a descrambler that starts from a different seed.

// File: rtl/scr66_pkg.sv
// Package: shared widths and tap positions for the 66-bit block scrambler.
// Assumes the x^58 + x^39 + 1 polynomial; taps are state indices where
// s[0] is the newest bit, so s[k] is the bit delayed by k+1 positions.
package scr66_pkg;
    localparam int unsigned SCR_STATE_W  = 58;
    localparam int unsigned SCR_TAP_NEAR = 38;
    localparam int unsigned SCR_TAP_FAR  = 57;
    localparam int unsigned SCR_PAY_W    = 64;
    localparam int unsigned SCR_HDR_W    = 2;

    typedef enum logic {
        SCR_MODE_TX = 1'b0,
        SCR_MODE_RX = 1'b1
    } scr_mode_e;
endpackage

// File: rtl/scr66_lfsr_step.sv
// Module: combinational one-block step of the multiplicative LFSR.
// Processes PAY_W bits LSB first. Each output bit is the data bit XOR
// the two tap bits. The state then shifts up, taking in either the output
// bit (scramble) or the input bit (descramble).
// Assumes TAP_NEAR < TAP_FAR < STATE_W.
module scr66_lfsr_step
    import scr66_pkg::*;
#(
    parameter int unsigned STATE_W  = SCR_STATE_W,
    parameter int unsigned TAP_NEAR = SCR_TAP_NEAR,
    parameter int unsigned TAP_FAR  = SCR_TAP_FAR,
    parameter int unsigned PAY_W    = SCR_PAY_W
) (
    input  logic [STATE_W-1:0] state_i,
    input  logic [PAY_W-1:0]   data_i,
    input  scr_mode_e          mode_i,
    output logic [STATE_W-1:0] state_o,
    output logic [PAY_W-1:0]   data_o
);

    // Unrolled bit-serial walk over the payload, one bit per iteration.
    always_comb begin
        logic [STATE_W-1:0] s;
        logic               o;
        logic               fb;
        s      = state_i;
        data_o = '0;
        for (int i = 0; i < int'(PAY_W); i++) begin
            o         = data_i[i] ^ s[TAP_NEAR] ^ s[TAP_FAR];
            data_o[i] = o;
            fb        = (mode_i == SCR_MODE_RX) ? data_i[i] : o;
            s         = {s[STATE_W-2:0], fb};
        end
        state_o = s;
    end

endmodule

// File: rtl/scr66_state_reg.sv
// Module: LFSR state register with seed load.
// During reset, it loads seed_i when seed_override is set, or all ones
// otherwise. After reset, it takes next_i only on cycles with advance high.
module scr66_state_reg #(
    parameter int unsigned STATE_W = scr66_pkg::SCR_STATE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seed_override,
    input  logic [STATE_W-1:0] seed_i,
    input  logic               advance,
    input  logic [STATE_W-1:0] next_i,
    output logic [STATE_W-1:0] state_o
);

    logic [STATE_W-1:0] state_q;

    // Seed load in reset, otherwise advance on valid blocks only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= seed_override ? seed_i : {STATE_W{1'b1}};
        end else if (advance) begin
            state_q <= next_i;
        end
    end

    assign state_o = state_q;

    // R5 and R6: first cycle after reset holds the selected seed.
    p_reset_seed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |->
            state_q == ($past(seed_override) ? $past(seed_i) : {STATE_W{1'b1}}));

    // R9: idle cycles leave the state untouched.
    p_state_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(state_q));

endmodule

// File: rtl/scr66_out_stage.sv
// Module: output register for the 66-bit block.
// Captures the header and the processed payload on valid cycles and holds
// them otherwise. The strobe is delayed by one clock. Clears on reset.
module scr66_out_stage #(
    parameter int unsigned HDR_W = scr66_pkg::SCR_HDR_W,
    parameter int unsigned PAY_W = scr66_pkg::SCR_PAY_W,
    localparam int unsigned BLK_W = HDR_W + PAY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid_i,
    input  logic [HDR_W-1:0] in_hdr_i,
    input  logic [PAY_W-1:0] in_pay_i,
    output logic             out_valid_o,
    output logic [BLK_W-1:0] out_block_o
);

    // Strobe delay and block capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            out_block_o <= '0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                out_block_o <= {in_pay_i, in_hdr_i};
            end
        end
    end

    // R10: strobe is the input strobe one clock later.
    p_valid_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid_o == $past(in_valid_i));

    // R2: header of a valid block reappears unchanged.
    p_hdr_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(in_valid_i) |->
            out_block_o[HDR_W-1:0] == $past(in_hdr_i));

    // R9: output word holds after an idle cycle.
    p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(in_valid_i) |-> $stable(out_block_o));

endmodule

// File: rtl/pcs_scrambler66.sv
// Module: self-synchronizing 64b/66b payload scrambler and descrambler.
// Splits the block into header and payload. The payload goes through the
// LFSR step. The header bypasses the step and is registered beside the
// processed payload. Assumes descramble is held static outside reset.
module pcs_scrambler66
    import scr66_pkg::*;
#(
    parameter int unsigned STATE_W  = SCR_STATE_W,
    parameter int unsigned TAP_NEAR = SCR_TAP_NEAR,
    parameter int unsigned TAP_FAR  = SCR_TAP_FAR,
    parameter int unsigned PAY_W    = SCR_PAY_W,
    parameter int unsigned HDR_W    = SCR_HDR_W,
    localparam int unsigned BLK_W   = HDR_W + PAY_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               descramble,
    input  logic               seed_override,
    input  logic [STATE_W-1:0] seed_i,
    input  logic               in_valid,
    input  logic [BLK_W-1:0]   in_block,
    output logic               out_valid,
    output logic [BLK_W-1:0]   out_block
);

    logic [HDR_W-1:0]   hdr;
    logic [PAY_W-1:0]   pay_in;
    logic [PAY_W-1:0]   pay_out;
    logic [STATE_W-1:0] state_cur;
    logic [STATE_W-1:0] state_nxt;
    scr_mode_e          mode;

    // Field split and mode decode.
    always_comb begin
        hdr    = in_block[HDR_W-1:0];
        pay_in = in_block[BLK_W-1:HDR_W];
        mode   = descramble ? SCR_MODE_RX : SCR_MODE_TX;
    end

    scr66_lfsr_step #(
        .STATE_W (STATE_W),
        .TAP_NEAR(TAP_NEAR),
        .TAP_FAR (TAP_FAR),
        .PAY_W   (PAY_W)
    ) u_step (
        .state_i(state_cur),
        .data_i (pay_in),
        .mode_i (mode),
        .state_o(state_nxt),
        .data_o (pay_out)
    );

    scr66_state_reg #(
        .STATE_W(STATE_W)
    ) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .seed_override(seed_override),
        .seed_i       (seed_i),
        .advance      (in_valid),
        .next_i       (state_nxt),
        .state_o      (state_cur)
    );

    scr66_out_stage #(
        .HDR_W(HDR_W),
        .PAY_W(PAY_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (in_valid),
        .in_hdr_i   (hdr),
        .in_pay_i   (pay_out),
        .out_valid_o(out_valid),
        .out_block_o(out_block)
    );

endmodule

// File: tb/test_pcs_scrambler66.sv
`timescale 1ns/1ps
module test_pcs_scrambler66;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        a_desc, a_ovr, b_ovr;
    logic [57:0] a_seed, b_seed;
    logic        a_vin;
    logic [65:0] a_blk;
    logic        a_vout, b_vout;
    logic [65:0] a_bout, b_bout;

    int checks = 0;
    int errors = 0;
    logic [57:0] ms;      // bench model state for instance A
    bit          m_desc;  // bench model mode for instance A
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    pcs_scrambler66 i_pcs_scrambler66 (
        .clk(clk), .rst_n(rst_n), .descramble(a_desc),
        .seed_override(a_ovr), .seed_i(a_seed),
        .in_valid(a_vin), .in_block(a_blk),
        .out_valid(a_vout), .out_block(a_bout)
    );

    pcs_scrambler66 i_pcs_scrambler66_rx (
        .clk(clk), .rst_n(rst_n), .descramble(1'b1),
        .seed_override(b_ovr), .seed_i(b_seed),
        .in_valid(a_vout), .in_block(a_bout),
        .out_valid(b_vout), .out_block(b_bout)
    );

    // Bit-serial model written from R3 and R7.
    function automatic logic [63:0] mdl(inout logic [57:0] s,
                                        input logic [63:0] d, input bit desc);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) begin
            r[i] = d[i] ^ s[38] ^ s[57];
            s    = {s[56:0], desc ? d[i] : r[i]};
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reset both instances with the given seed settings; check reset outputs (R10).
    task automatic do_reset(input bit desc, input bit ao, input logic [57:0] as,
                            input bit bo, input logic [57:0] bs);
        @(negedge clk);
        rst_n = 1'b0; a_desc = desc; a_ovr = ao; a_seed = as;
        b_ovr = bo; b_seed = bs; a_vin = 1'b0; a_blk = '0;
        repeat (2) @(negedge clk);
        chk("R10 reset out_valid", {65'd0, a_vout}, 66'd0);
        chk("R10 reset out_block", a_bout, 66'd0);
        ms = ao ? as : {58{1'b1}};
        m_desc = desc;
        rst_n = 1'b1;
    endtask

    // Drive one valid block at a negedge and check it one clock later (R1, R3).
    task automatic send_check(input logic [65:0] blk, input string req);
        logic [65:0] exp;
        a_vin = 1'b1; a_blk = blk;
        @(negedge clk);
        a_vin = 1'b0;
        exp = {mdl(ms, blk[65:2], m_desc), blk[1:0]};
        chk({req, " out_valid"}, {65'd0, a_vout}, 66'd1);
        chk(req, a_bout, exp);
    endtask

    // R5, R3, R1, R4: default all-ones seed, back-to-back blocks.
    task automatic t_default_seed();
        do_reset(1'b0, 1'b0, 58'h155, 1'b0, '0);
        send_check({64'h0, 2'b01}, "R5 zero payload from all-ones seed");
        send_check({64'h0000_0000_0000_0001, 2'b10}, "R1 payload lsb first");
        send_check({64'hFFFF_FFFF_FFFF_FFFF, 2'b01}, "R4 state carried");
        send_check({64'h8000_0000_0000_0000, 2'b10}, "R3 taps");
    endtask

    // R6: seed port override.
    task automatic t_seed();
        do_reset(1'b0, 1'b1, 58'h2AB_CDEF_0123_4567, 1'b0, '0);
        send_check({64'h0, 2'b01}, "R6 seed override zero payload");
        send_check({64'h0123_4567_89AB_CDEF, 2'b10}, "R6 seed override data");
    endtask

    // R9, R10: idle cycles hold state and output.
    task automatic t_gap();
        logic [65:0] held;
        do_reset(1'b0, 1'b0, '0, 1'b0, '0);
        send_check({64'hDEAD_BEEF_0BAD_F00D, 2'b01}, "R9 before gap");
        held  = a_bout;
        a_blk = {64'hFFFF_0000_FFFF_0000, 2'b11};
        repeat (3) @(negedge clk);
        chk("R10 out_valid low in gap", {65'd0, a_vout}, 66'd0);
        chk("R9 out_block held in gap", a_bout, held);
        send_check({64'h1357_9BDF_2468_ACE0, 2'b10}, "R9 state not advanced in gap");
    endtask

    // R2: every header code passes unchanged.
    task automatic t_header();
        do_reset(1'b0, 1'b0, '0, 1'b0, '0);
        for (int h = 0; h < 4; h++) begin
            send_check({{$urandom(), $urandom()}, 2'(h)}, "R2 header bypass");
        end
    endtask

    // R7, R8: descramble mode on A recovers data scrambled from another seed.
    task automatic t_descramble();
        logic [57:0] sx;
        logic [63:0] p, c;
        do_reset(1'b1, 1'b0, '0, 1'b0, '0);
        sx = 58'h0F0_F0F0_F0F0_F0F0;
        for (int n = 0; n < 4; n++) begin
            p = {$urandom(), $urandom()};
            c = mdl(sx, p, 1'b0);
            send_check({c, 2'b01}, "R7 descramble feedback");
            if (n >= 1) chk("R8 descramble recovers payload", {a_bout[65:2], 2'b01}, {p, 2'b01});
        end
    endtask

    // R8: scrambler into descrambler, different seeds, pipelined.
    task automatic t_loopback();
        logic [65:0] hist [0:19];
        do_reset(1'b0, 1'b1, 58'h3FF_0000_1234_ABCD, 1'b1, 58'h001_2345_6789_ABCD);
        for (int n = 0; n < 22; n++) begin
            @(negedge clk);
            if (n >= 2) begin
                chk("R8 loopback out_valid", {65'd0, b_vout}, 66'd1);
                chk("R2 loopback header", {64'd0, b_bout[1:0]}, {64'd0, hist[n-2][1:0]});
                if (n >= 3) chk("R8 loopback payload", b_bout, hist[n-2]);
            end
            if (n < 20) begin
                hist[n] = {$urandom(), $urandom(), ($urandom() % 2 == 0) ? 2'b01 : 2'b10};
                a_vin = 1'b1; a_blk = hist[n];
            end else begin
                a_vin = 1'b0;
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; a_desc = 1'b0; a_ovr = 1'b0; b_ovr = 1'b0;
        a_seed = '0; b_seed = '0; a_vin = 1'b0; a_blk = '0;
        t_default_seed();
        t_seed();
        t_gap();
        t_header();
        t_descramble();
        t_loopback();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule